// File: doc/BRIEF.md
# Coherency Request Enable Controller

This block holds the snoop-request and distributed-virtual-memory (DVM) request enables for each slave port of a small coherent interconnect. There are five ports: two full-coherence ports for CPU clusters and three I/O-coherent lite ports. Software writes a port's enable bits through a simple register bus. The block presents the new levels to a port model and raises a change request toward it. The request stays up until the port model acknowledges it.

A global status bit reads 1 while any port change is still in flight. Software changes a cluster's enables only through that port's own register. It then polls the status bit until it reads 0. Each port runs its own three-state machine:
- `ST_IDLE` moves to `ST_BUSY` on a write to that port.
- `ST_BUSY` moves back to `ST_IDLE` on acknowledge when no further write is waiting.
- `ST_BUSY` moves to `ST_GAP` on acknowledge when a further write is waiting.
- `ST_GAP` moves to `ST_BUSY` one cycle later and presents the waiting value.

The register map uses windows 4 KiB apart. Window 0 is the control window, and its status register sits at byte offset 0xC. Port `i` (0 to 4, full ports first) has its control register at offset 0x0 of window `i+1`, at address `(i+1)<<12`.

Top module: `snp_port_ctrl`

## Requirements
- R1: After reset, every snoop and DVM enable output is 0, every change request is 0, and the status bit reads 0.
- R2: A write to a port's control register has the following effects:
  - Bit 0 sets the snoop enable and bit 1 sets the DVM enable. Writing 0x3 turns both on and writing 0 turns both off.
  - After the write's clock edge, the levels appear on `snoop_en`/`dvm_en` together with a raised `chg_req` for that port.
  - `chg_req` stays high until `chg_ack` is seen with it.
  - It drops in the cycle after that acknowledge.
- R3: Bit 0 of the status register (address 0x000C) reads 1 while any port has a change outstanding or waiting. It reads 0 from the cycle after the last outstanding acknowledge.
- R4: Writing the value a port already holds still raises its request and sets the status bit until acknowledged.
- R5: Reading a port control register returns the last value written to it in bits 1:0, with bits 31:2 zero.
- R6: A write to a port whose request is outstanding is held, not dropped. On the acknowledge, the request drops for exactly one cycle (`ST_GAP`). It then rises again with the held value on the enable outputs.
- R7: When several writes arrive while a request is outstanding, only the newest is held and applied.
- R8: An acknowledge on a port with no outstanding request has no effect on its outputs or on the status bit.
- R9: A write and an acknowledge for the same port in the same cycle: the acknowledge completes the current change, and the written value follows through `ST_GAP` as in R6.
- R10: Writes to the status register or to any other unmapped offset change nothing, and reads of unmapped offsets return 0.
- R11: While a port's request is up and not acknowledged, its enable outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe for the current cycle |
| bus_addr | input | 16 | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| snoop_en | output | 5 | Per-port snoop-request enable level |
| dvm_en | output | 5 | Per-port DVM-request enable level |
| chg_req | output | 5 | Per-port change request toward the port model |
| chg_ack | input | 5 | Per-port acknowledge from the port model |

## Verification
A new register write can land on a port in the same clock cycle in which the port model acknowledges that port's previous change. The acknowledge must close the old change, and the write must survive into a one-cycle gap followed by a fresh request. The bench provokes this with a directed write-plus-acknowledge cycle. It also provokes it with a long stretch of random writes and random acknowledges across all ports. Every cycle, a behavioural per-port model is compared against the request, enable and readback outputs, so any lost or misordered value shows up in the cycle it occurs.

// File: rtl/snp_pkg.sv
package snp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_GAP  = 2'd2
    } port_st_e;

    localparam int EN_W = 2;   // bit0 snoop, bit1 DVM
endpackage

// File: rtl/snp_addr_dec.sv
module snp_addr_dec #(
    parameter int ADDR_W    = 16,
    parameter int WIN_SHIFT = 12,
    parameter int NUM_PORTS = 5,
    parameter int STAT_OFS  = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output logic                 stat_sel,
    output logic [NUM_PORTS-1:0] port_sel,
    output logic [NUM_PORTS-1:0] port_wr
);
    localparam int WIN_W = ADDR_W - WIN_SHIFT;

    logic [WIN_W-1:0]     win;
    logic [WIN_SHIFT-1:0] ofs;

    assign win      = addr[ADDR_W-1:WIN_SHIFT];
    assign ofs      = addr[WIN_SHIFT-1:0];
    assign stat_sel = (win == '0) && (ofs == WIN_SHIFT'(STAT_OFS));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_dec
        assign port_sel[i] = (win == WIN_W'(i + 1)) && (ofs == '0);
        assign port_wr[i]  = wr && port_sel[i];
    end
endmodule

// File: rtl/snp_port_fsm.sv
module snp_port_fsm
    import snp_pkg::*;
#(
    parameter int W = EN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_val,
    input  logic         ack,
    output logic [W-1:0] en_o,
    output logic [W-1:0] shadow_o,
    output logic         req_o,
    output logic         busy_o
);
    port_st_e     st, st_nxt;
    logic [W-1:0] applied, held, shadow;
    logic         held_vld;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (wr_hit) st_nxt = ST_BUSY;
            ST_BUSY: if (ack)    st_nxt = (held_vld || wr_hit) ? ST_GAP : ST_IDLE;
            ST_GAP:              st_nxt = ST_BUSY;
            default:             st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            applied  <= '0;
            held     <= '0;
            held_vld <= 1'b0;
            shadow   <= '0;
        end else begin
            st <= st_nxt;
            if (wr_hit) shadow <= wr_val;
            case (st)
                ST_IDLE: if (wr_hit) applied <= wr_val;
                ST_BUSY: if (wr_hit) begin
                    held     <= wr_val;
                    held_vld <= 1'b1;
                end
                ST_GAP: begin
                    applied <= held;
                    if (wr_hit) begin
                        held     <= wr_val;
                        held_vld <= 1'b1;
                    end else begin
                        held_vld <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        en_o     = applied;
        shadow_o = shadow;
        req_o    = (st == ST_BUSY);
        busy_o   = (st != ST_IDLE);
    end

    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack) |=> req_o);
    p_req_drop_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack) |=> !req_o);
    p_gap_rerequest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !req_o) |=> req_o);
    p_en_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack) |=> $stable(en_o));
    p_idle_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !wr_hit) |=> (!busy_o && $stable(en_o)));
endmodule

// File: rtl/snp_port_ctrl.sv
module snp_port_ctrl
    import snp_pkg::*;
#(
    parameter int NUM_FULL  = 2,
    parameter int NUM_LITE  = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int WIN_SHIFT = 12,
    parameter int STAT_OFS  = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_FULL+NUM_LITE-1:0]     snoop_en,
    output logic [NUM_FULL+NUM_LITE-1:0]     dvm_en,
    output logic [NUM_FULL+NUM_LITE-1:0]     chg_req,
    input  logic [NUM_FULL+NUM_LITE-1:0]     chg_ack
);
    localparam int NUM_PORTS = NUM_FULL + NUM_LITE;

    logic                 stat_sel;
    logic [NUM_PORTS-1:0] port_sel, port_wr, busy;
    logic [EN_W-1:0]      shadow [NUM_PORTS];
    logic [EN_W-1:0]      en     [NUM_PORTS];
    logic                 pending;
    logic                 unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:EN_W];

    snp_addr_dec #(
        .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT),
        .NUM_PORTS(NUM_PORTS), .STAT_OFS(STAT_OFS)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr),
        .stat_sel(stat_sel), .port_sel(port_sel), .port_wr(port_wr)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        snp_port_fsm #(.W(EN_W)) u_fsm (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(port_wr[i]), .wr_val(bus_wdata[EN_W-1:0]),
            .ack(chg_ack[i]),
            .en_o(en[i]), .shadow_o(shadow[i]),
            .req_o(chg_req[i]), .busy_o(busy[i])
        );
        assign snoop_en[i] = en[i][0];
        assign dvm_en[i]   = en[i][1];
    end

    assign pending = |busy;

    always_comb begin
        bus_rdata = '0;
        if (stat_sel) bus_rdata[0] = pending;
        for (int i = 0; i < NUM_PORTS; i++)
            if (port_sel[i]) bus_rdata[EN_W-1:0] = shadow[i];
    end

    p_req_implies_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_req) |-> pending);
    p_pending_fall_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(|(chg_ack & chg_req)));
    p_write_raises_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_wr) |=> pending);
endmodule

// File: tb/snp_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module snp_port_ctrl_tb_top;
    localparam int NP = 5;
    localparam logic [15:0] STAT = 16'h000C;
    localparam logic [15:0] BAD  = 16'h1004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] snoop_en, dvm_en, chg_req;
    logic [NP-1:0] chg_ack = '0;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    snp_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snoop_en(snoop_en),
        .dvm_en(dvm_en), .chg_req(chg_req), .chg_ack(chg_ack)
    );

    function automatic logic [15:0] paddr(int p);
        return 16'((p + 1) << 12);
    endfunction

    // behavioural reference model
    logic [1:0] m_en [NP];
    logic [1:0] m_lw [NP];
    logic [1:0] m_qd [NP];
    bit m_out [NP];
    bit m_gap [NP];
    bit m_qv  [NP];

    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            bit w;
            logic [1:0] d;
            w = bus_wr && (bus_addr == paddr(p));
            d = bus_wdata[1:0];
            if (!rst_n) begin
                m_en[p] = 0; m_lw[p] = 0; m_qd[p] = 0;
                m_out[p] = 0; m_gap[p] = 0; m_qv[p] = 0;
            end else begin
                if (m_gap[p]) begin
                    m_en[p] = m_qd[p]; m_out[p] = 1; m_gap[p] = 0;
                    if (w) begin m_qd[p] = d; m_qv[p] = 1; end else m_qv[p] = 0;
                end else if (m_out[p]) begin
                    if (w) begin m_qd[p] = d; m_qv[p] = 1; end
                    if (chg_ack[p]) begin
                        m_out[p] = 0;
                        if (m_qv[p]) m_gap[p] = 1;
                    end
                end else if (w) begin
                    m_en[p] = d; m_out[p] = 1;
                end
                if (w) m_lw[p] = d;
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [15:0] a);
        logic [31:0] r;
        r = '0;
        if (a == STAT)
            for (int p = 0; p < NP; p++) if (m_out[p] || m_gap[p]) r[0] = 1'b1;
        for (int p = 0; p < NP; p++) if (a == paddr(p)) r[1:0] = m_lw[p];
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < NP; p++) begin
                chk("R2 enables", {30'd0, dvm_en[p], snoop_en[p]}, {30'd0, m_en[p]});
                chk("R6 request", {31'd0, chg_req[p]}, {31'd0, m_out[p]});
            end
            chk((bus_addr == STAT) ? "R3 status" : "R5 readback", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic drive(bit w, logic [15:0] a, logic [31:0] d, logic [NP-1:0] k);
        bus_wr = w; bus_addr = a; bus_wdata = d; chg_ack = k;
        @(negedge clk); #1;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1; n_chk++; n_err++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        drive(0, STAT, 0, 0);
        // R1
        chk("R1 snoop", {27'd0, snoop_en}, 0);
        chk("R1 dvm", {27'd0, dvm_en}, 0);
        chk("R1 req", {27'd0, chg_req}, 0);
        chk("R1 status", bus_rdata, 0);

        // R2 / R3
        drive(1, paddr(0), 3, 0);
        chk("R2 snoop0", {31'd0, snoop_en[0]}, 1);
        chk("R2 dvm0", {31'd0, dvm_en[0]}, 1);
        chk("R2 req0", {31'd0, chg_req[0]}, 1);
        drive(0, STAT, 0, 0);
        chk("R3 busy", bus_rdata, 1);
        chk("R2 req held", {31'd0, chg_req[0]}, 1);
        drive(0, STAT, 0, 5'b00001);
        chk("R2 req dropped", {31'd0, chg_req[0]}, 0);
        chk("R3 cleared", bus_rdata, 0);

        // R3 two ports
        drive(1, paddr(1), 1, 0);
        drive(1, paddr(3), 2, 0);
        drive(0, STAT, 0, 5'b00010);
        chk("R3 one left", bus_rdata, 1);
        drive(0, STAT, 0, 5'b01000);
        chk("R3 all done", bus_rdata, 0);
        chk("R2 p1", {30'd0, dvm_en[1], snoop_en[1]}, 1);
        chk("R2 p3", {30'd0, dvm_en[3], snoop_en[3]}, 2);

        // R4 same value
        drive(1, paddr(1), 1, 0);
        chk("R4 req", {31'd0, chg_req[1]}, 1);
        drive(0, STAT, 0, 0);
        chk("R4 status", bus_rdata, 1);
        drive(0, STAT, 0, 5'b00010);
        chk("R4 status clear", bus_rdata, 0);

        // R6 queued write
        drive(1, paddr(2), 3, 0);
        drive(1, paddr(2), 0, 0);
        chk("R11 en held", {30'd0, dvm_en[2], snoop_en[2]}, 3);
        drive(0, STAT, 0, 5'b00100);
        chk("R6 gap req", {31'd0, chg_req[2]}, 0);
        chk("R6 gap status", bus_rdata, 1);
        drive(0, STAT, 0, 0);
        chk("R6 rerequest", {31'd0, chg_req[2]}, 1);
        chk("R6 new en", {30'd0, dvm_en[2], snoop_en[2]}, 0);
        drive(0, STAT, 0, 5'b00100);
        chk("R6 done", bus_rdata, 0);

        // R7 newest wins
        drive(1, paddr(4), 1, 0);
        drive(1, paddr(4), 2, 0);
        drive(1, paddr(4), 3, 0);
        drive(0, STAT, 0, 5'b10000);
        drive(0, STAT, 0, 0);
        chk("R7 newest", {30'd0, dvm_en[4], snoop_en[4]}, 3);
        drive(0, STAT, 0, 5'b10000);
        chk("R7 done", bus_rdata, 0);

        // R8 stray ack
        drive(0, STAT, 0, 5'b11111);
        chk("R8 req", {27'd0, chg_req}, 0);
        chk("R8 status", bus_rdata, 0);
        chk("R8 en0", {30'd0, dvm_en[0], snoop_en[0]}, 3);

        // R9 write with ack
        drive(1, paddr(0), 1, 0);
        drive(1, paddr(0), 2, 5'b00001);
        chk("R9 gap", {31'd0, chg_req[0]}, 0);
        chk("R9 old en", {30'd0, dvm_en[0], snoop_en[0]}, 1);
        drive(0, STAT, 0, 0);
        chk("R9 new en", {30'd0, dvm_en[0], snoop_en[0]}, 2);
        drive(0, STAT, 0, 5'b00001);
        chk("R9 done", bus_rdata, 0);

        // R10 / R5
        drive(1, STAT, 3, 0);
        chk("R10 status write", bus_rdata, 0);
        chk("R10 no req", {27'd0, chg_req}, 0);
        drive(1, BAD, 0, 0);
        drive(0, paddr(0), 0, 0);
        chk("R10 p0 kept", bus_rdata, 2);
        drive(0, BAD, 0, 0);
        chk("R10 unmapped read", bus_rdata, 0);
        drive(1, paddr(3), 32'hFFFF_FFFD, 0);
        drive(0, paddr(3), 0, 5'b01000);
        chk("R5 upper zero", bus_rdata, 1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [15:0] a;
            sel = $urandom_range(0, 6);
            a = (sel < 5) ? paddr(sel) : ((sel == 5) ? STAT : BAD);
            drive(bit'($urandom_range(0, 1)), a, $urandom, NP'($urandom));
        end
        for (int i = 0; i < 8; i++) drive(0, STAT, 0, '1);
        chk("R3 drained", bus_rdata, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule